// File: doc/BRIEF.md
# Shift, Byte-Clear and Bit-Scan Unit

A purely combinational 64-bit datapath helper. One 3-bit operation code picks what the result is, computed from two 64-bit operands `a_i` and `b_i`. The operations are:

- three shifts: logical left, logical right and sign-filling right;
- a byte-clear that blanks selected bytes of `a_i` under a per-byte mask;
- a scan that reports the index of the highest set bit of `a_i`;
- an unsigned minimum of the two operands.

The result settles in the same cycle the inputs are applied, so the unit can sit inside an execute stage next to an adder. It holds no state.

Shift amounts come from the low six bits of `b_i`. The byte-clear mask comes from the low eight bits of `b_i`. A separate flag `scan_zero_o` tells the consumer that the bit-scan saw an all-zero operand. In that case the numeric result of 0 would otherwise be ambiguous.

Top module: `bm_shift_zap_unit`

## Requirements
- R1: With op = 0 (shift left), res_o equals a_i shifted left by b_i[5:0] places, with zeros entering at bit 0 and bits leaving bit 63 lost.
- R2: With op = 1 (logical right shift), res_o equals a_i shifted right by b_i[5:0] places, with zeros entering at bit 63.
- R3: With op = 2 (sign-filling right shift), res_o equals a_i shifted right by b_i[5:0] places, with every vacated position taking the value of a_i[63].
- R4: For the three shift operations, b_i[63:6] has no effect on res_o.
- R5: With op = 3 (byte clear), for each n in 0..7, res_o[8n+7:8n] is zero when b_i[n] is 1 and equals a_i[8n+7:8n] when b_i[n] is 0; b_i[63:8] has no effect.
- R6: With op = 4 (bit scan) and a_i nonzero, res_o is the index of the highest set bit of a_i, zero-extended to 64 bits (a_i = 255 gives 7), and scan_zero_o is 0.
- R7: With op = 4 and a_i equal to zero, res_o is 0 and scan_zero_o is 1.
- R8: With op = 5 (unsigned minimum), res_o equals whichever of a_i and b_i is smaller when both are read as unsigned numbers.
- R9: Op codes 6 and 7 give res_o = 0. scan_zero_o is 0 for every op code other than 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code (0 left, 1 right logical, 2 right sign-fill, 3 byte clear, 4 bit scan, 5 unsigned min) |
| a_i | input | 64 | Data operand |
| b_i | input | 64 | Shift amount, byte mask, or second compare operand |
| res_o | output | 64 | Operation result |
| scan_zero_o | output | 1 | High when the bit scan sees an all-zero operand |

## Verification
The embedded checks assume that every input bit carries a defined 0 or 1, with no X or Z. They also assume that the inputs are steady at the moment the comparison is evaluated. Both assumptions hold because the unit is free of state.

The bench drives every operand and the op code to known values before each sample. It changes them only from a task, and it samples two time units later, well before the next change. The bench deliberately places nonzero data in b_i[63:6] and b_i[63:8]. This shows that the immediate checks, like the outputs, depend only on the low fields of b_i.

// File: rtl/bm_pkg.sv
package bm_pkg;
   typedef enum logic [2:0] {
      OP_SHL  = 3'd0,
      OP_SHR  = 3'd1,
      OP_SAR  = 3'd2,
      OP_ZAP  = 3'd3,
      OP_SCAN = 3'd4,
      OP_MINU = 3'd5,
      OP_RSV6 = 3'd6,
      OP_RSV7 = 3'd7
   } bm_op_e;
endpackage

// File: rtl/bm_shifter.sv
module bm_shifter #(
   parameter int W      = 64,
   parameter bit BARREL = 1'b1,
   localparam int SHW   = $clog2(W)
) (
   input  logic [W-1:0]   data_i,
   input  logic [SHW-1:0] amt_i,
   input  logic           left_i,
   input  logic           arith_i,
   output logic [W-1:0]   data_o
);
   if (W < 2 || (W & (W - 1)) != 0) begin : g_bad_w
      $error("bm_shifter: W must be a power of two");
   end

   if (BARREL) begin : g_barrel
      logic [W-1:0] rev_in, rev_out, pre;
      logic [W-1:0] stage [0:SHW];
      logic         fill;

      for (genvar i = 0; i < W; i++) begin : g_rev
         assign rev_in[i]  = data_i[W-1-i];
         assign rev_out[i] = stage[SHW][W-1-i];
      end

      assign pre      = left_i ? rev_in : data_i;
      assign fill     = arith_i & ~left_i & data_i[W-1];
      assign stage[0] = pre;

      for (genvar k = 0; k < SHW; k++) begin : g_stage
         localparam int SH = 1 << k;
         assign stage[k+1] = amt_i[k] ? {{SH{fill}}, stage[k][W-1:SH]} : stage[k];
      end

      assign data_o = left_i ? rev_out : stage[SHW];
   end else begin : g_operator
      always_comb begin
         if (left_i)       data_o = data_i << amt_i;
         else if (arith_i) data_o = W'($signed(data_i) >>> amt_i);
         else              data_o = data_i >> amt_i;
      end
   end

   always_comb begin
      if (amt_i == '0)
         assert_zero_amount_identity_R1: assert (data_o == data_i);
      if (left_i)
         assert_left_low_bits_clear_R1: assert ((data_o & ~({W{1'b1}} << amt_i)) == '0);
      if (!left_i && !arith_i)
         assert_right_high_bits_clear_R2: assert ((data_o & ~({W{1'b1}} >> amt_i)) == '0);
      if (!left_i && arith_i)
         assert_sign_kept_R3: assert (data_o[W-1] == data_i[W-1]);
   end
endmodule

// File: rtl/bm_zapper.sv
module bm_zapper #(
   parameter int W     = 64,
   localparam int LANES = W / 8
) (
   input  logic [W-1:0]     data_i,
   input  logic [LANES-1:0] mask_i,
   output logic [W-1:0]     data_o
);
   if (W % 8 != 0 || W < 8) begin : g_bad_w
      $error("bm_zapper: W must be a multiple of 8");
   end

   for (genvar n = 0; n < LANES; n++) begin : g_lane
      assign data_o[8*n +: 8] = mask_i[n] ? 8'h00 : data_i[8*n +: 8];
   end

   always_comb begin
      assert_zap_sets_no_bit_R5: assert ((data_o & ~data_i) == '0);
      if (mask_i == '0)
         assert_empty_mask_passes_R5: assert (data_o == data_i);
   end
endmodule

// File: rtl/bm_msb_scan.sv
module bm_msb_scan #(
   parameter int W    = 64,
   localparam int SHW = $clog2(W)
) (
   input  logic [W-1:0]   data_i,
   output logic [SHW-1:0] idx_o,
   output logic           none_o
);
   always_comb begin
      idx_o  = '0;
      none_o = 1'b1;
      for (int i = 0; i < W; i++) begin
         if (data_i[i]) begin
            idx_o  = SHW'(i);
            none_o = 1'b0;
         end
      end
   end

   always_comb begin
      if (!none_o) begin
         assert_scan_hits_set_bit_R6: assert (data_i[idx_o]);
         assert_scan_nothing_above_R6: assert ((data_i >> idx_o) == W'(1));
      end else begin
         assert_scan_zero_input_R7: assert (data_i == '0 && idx_o == '0);
      end
   end
endmodule

// File: rtl/bm_shift_zap_unit.sv
module bm_shift_zap_unit
   import bm_pkg::*;
#(
   parameter int W      = 64,
   parameter bit BARREL = 1'b1,
   localparam int SHW   = $clog2(W),
   localparam int LANES = W / 8
) (
   input  logic [2:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] res_o,
   output logic         scan_zero_o
);
   if (W < 16 || (W & (W - 1)) != 0) begin : g_bad_w
      $error("bm_shift_zap_unit: W must be a power of two of at least 16");
   end

   bm_op_e       op;
   logic [W-1:0] sh_res, zap_res;
   logic [SHW-1:0] scan_idx;
   logic         scan_none;

   assign op = bm_op_e'(op_i);

   bm_shifter #(.W(W), .BARREL(BARREL)) u_shift (
      .data_i  (a_i),
      .amt_i   (b_i[SHW-1:0]),
      .left_i  (op == OP_SHL),
      .arith_i (op == OP_SAR),
      .data_o  (sh_res)
   );

   bm_zapper #(.W(W)) u_zap (
      .data_i (a_i),
      .mask_i (b_i[LANES-1:0]),
      .data_o (zap_res)
   );

   bm_msb_scan #(.W(W)) u_scan (
      .data_i (a_i),
      .idx_o  (scan_idx),
      .none_o (scan_none)
   );

   always_comb begin
      res_o       = '0;
      scan_zero_o = 1'b0;
      case (op)
         OP_SHL, OP_SHR, OP_SAR: res_o = sh_res;
         OP_ZAP:  res_o = zap_res;
         OP_SCAN: begin
            res_o       = {{(W-SHW){1'b0}}, scan_idx};
            scan_zero_o = scan_none;
         end
         OP_MINU: res_o = (a_i < b_i) ? a_i : b_i;
         default: res_o = '0;
      endcase
   end

   always_comb begin
      if (op == OP_MINU) begin
         assert_min_not_above_a_R8: assert (res_o <= a_i);
         assert_min_not_above_b_R8: assert (res_o <= b_i);
      end
      if (op == OP_RSV6 || op == OP_RSV7)
         assert_reserved_gives_zero_R9: assert (res_o == '0 && !scan_zero_o);
      if (scan_zero_o)
         assert_flag_only_on_scan_R9: assert (op == OP_SCAN && res_o == '0 && a_i == '0);
   end
endmodule

// File: tb/bm_shift_zap_unit_tb.sv
module bm_shift_zap_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op;
   logic [63:0] a, b;
   logic [63:0] res;
   logic        zf;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   bm_shift_zap_unit u_dut (
      .op_i(op), .a_i(a), .b_i(b), .res_o(res), .scan_zero_o(zf)
   );

   task automatic apply(input logic [2:0] o, input logic [63:0] x, input logic [63:0] y);
      op = o; a = x; b = y;
      #2;
   endtask

   task automatic check(input string tag, input logic [63:0] exp_r, input logic exp_z);
      n_chk++;
      if (res !== exp_r || zf !== exp_z) begin
         n_bad++;
         $display("FAIL %s: res=%h zf=%b expected res=%h zf=%b", tag, res, zf, exp_r, exp_z);
      end
   endtask

   function automatic logic [63:0] ref_scan(input logic [63:0] x);
      for (int i = 63; i >= 0; i--) if (x[i]) return 64'(i);
      return 64'd0;
   endfunction

   task automatic t_reset();
      apply(3'd0, 64'd0, 64'd0);
      check("R1 idle", 64'd0, 1'b0);
   endtask

   task automatic t_shl();
      logic [63:0] v = 64'h8123_4567_89ab_cdef;
      for (int s = 0; s < 64; s += 7) begin
         apply(3'd0, v, 64'(s));
         check("R1 shl", v << s, 1'b0);
      end
      apply(3'd0, v, 64'd63);
      check("R1 shl63", v << 63, 1'b0);
   endtask

   task automatic t_shr();
      logic [63:0] v = 64'hf0e1_d2c3_b4a5_9687;
      for (int s = 0; s < 64; s += 9) begin
         apply(3'd1, v, 64'(s));
         check("R2 shr", v >> s, 1'b0);
      end
   endtask

   task automatic t_sar();
      logic [63:0] neg = 64'h9000_0000_0000_0f0f;
      logic [63:0] pos = 64'h7000_0000_0000_0f0f;
      for (int s = 0; s < 64; s += 5) begin
         apply(3'd2, neg, 64'(s));
         check("R3 sar neg", 64'($signed(neg) >>> s), 1'b0);
         apply(3'd2, pos, 64'(s));
         check("R3 sar pos", pos >> s, 1'b0);
      end
      apply(3'd2, neg, 64'd63);
      check("R3 sar63", 64'hffff_ffff_ffff_ffff, 1'b0);
   endtask

   task automatic t_amount_field();
      logic [63:0] v = 64'h0123_4567_89ab_cdef;
      apply(3'd0, v, 64'hffff_ffff_ffff_ffc4);
      check("R4 shl upper b", v << 4, 1'b0);
      apply(3'd1, v, 64'h8000_0000_0000_0040);
      check("R4 shr upper b", v, 1'b0);
      apply(3'd2, 64'h8000_0000_0000_0000, 64'hdead_beef_0000_0001);
      check("R4 sar upper b", 64'hc000_0000_0000_0000, 1'b0);
   endtask

   task automatic t_zap();
      logic [63:0] v = 64'h1122_3344_5566_7788;
      logic [63:0] e;
      for (int m = 0; m < 256; m += 37) begin
         e = v;
         for (int n = 0; n < 8; n++) if (m[n]) e[8*n +: 8] = 8'h00;
         apply(3'd3, v, 64'hffff_ff00_0000_0000 | 64'(m));
         check("R5 zap", e, 1'b0);
      end
      apply(3'd3, v, 64'hff);
      check("R5 zap all", 64'd0, 1'b0);
      apply(3'd3, v, 64'hffff_ffff_ffff_ff00);
      check("R5 zap upper ignored", v, 1'b0);
   endtask

   task automatic t_scan();
      apply(3'd4, 64'd255, 64'd0);
      check("R6 scan 255", 64'd7, 1'b0);
      apply(3'd4, 64'h8000_0000_0000_0001, 64'd0);
      check("R6 scan top", 64'd63, 1'b0);
      apply(3'd4, 64'd1, 64'hffff);
      check("R6 scan one", 64'd0, 1'b0);
      for (int i = 0; i < 64; i += 11) begin
         logic [63:0] v = (64'd1 << i) | 64'h3;
         apply(3'd4, v, 64'd0);
         check("R6 scan walk", ref_scan(v), 1'b0);
      end
   endtask

   task automatic t_scan_zero();
      apply(3'd4, 64'd0, 64'h1234);
      check("R7 scan zero", 64'd0, 1'b1);
   endtask

   task automatic t_minu();
      apply(3'd5, 64'd5, 64'd9);
      check("R8 min small a", 64'd5, 1'b0);
      apply(3'd5, 64'hffff_ffff_ffff_fffe, 64'd3);
      check("R8 min unsigned", 64'd3, 1'b0);
      apply(3'd5, 64'h8000_0000_0000_0000, 64'h7fff_ffff_ffff_ffff);
      check("R8 min sign bit", 64'h7fff_ffff_ffff_ffff, 1'b0);
      apply(3'd5, 64'd42, 64'd42);
      check("R8 min equal", 64'd42, 1'b0);
   endtask

   task automatic t_reserved();
      apply(3'd6, 64'hffff, 64'd0);
      check("R9 op6", 64'd0, 1'b0);
      apply(3'd7, 64'd0, 64'd0);
      check("R9 op7", 64'd0, 1'b0);
      apply(3'd5, 64'd0, 64'd0);
      check("R9 flag low off scan", 64'd0, 1'b0);
   endtask

   initial begin
      op = '0; a = '0; b = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_shl();
      t_shr();
      t_sar();
      t_amount_field();
      t_zap();
      t_scan();
      t_scan_zero();
      t_minu();
      t_reserved();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: res=%h expected completion", res);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule